// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes bus write cycles aimed at a partitioned parallel NOR flash model. Each cycle brings a partition index and a 16-bit data word, with the command code in the low byte. The controller accepts one-cycle commands and two-cycle pairs, where a setup code is followed by a confirm or data cycle. It also handles suspend and resume of a running program or erase.

It keeps a status byte and chooses what a read returns: array data, the status byte, an identifier word or a query word. An embedded operation is stood in for by a down-counter. A pulse with the data word of the starting cycle tells the array model that an operation began. Erase takes longer than program and OTP writes.

The block also runs a buffered fast-program mode. In that mode, plain data cycles to the chosen partition each start a short program. A data cycle that arrives while the previous one is still running is dropped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data, status is 0x80 (bit 7 ready), busy is low and no operation pulse is given.
- R2: Code 0x40 followed by a data cycle to the same partition raises opStart for one cycle, with opData equal to that word. Status is selected for reads, and busy stays high for exactly PROG_CYCLES cycles after the data cycle, with status bit 7 low meanwhile.
- R3: Code 0x20 followed by 0xD0 to the same partition starts an erase that is busy for exactly ERASE_CYCLES cycles.
- R4: A second cycle to a different partition, or a wrong confirm code after erase setup, sets status bits 5 and 4, starts nothing and returns to idle.
- R5: Error bits 5 and 4 stay set until code 0x50 arrives while no operation is running. A 0x50 during a running operation has no effect.
- R6: Code 0xB0 during a program sets status bit 2, and during an erase it sets bit 6. While suspended, bit 7 reads 1 and the remaining busy time is frozen. Code 0xD0 resumes the operation for exactly the remaining cycles.
- R7: While a program is suspended, the pair 0x20 then 0xD0 is ignored: no erase starts, nothing resumes and the status stays 0x84.
- R8: While an erase is suspended, a program (0x40 plus data) may run. Status reads 0x40 during it and 0xC0 after it. A later 0xD0 finishes the erase with its saved remaining time.
- R9: Code 0x60 followed by 0x01, 0x2F or 0x03 to the same partition completes without error. Any other second code sets the sequence error of R4.
- R10: Code 0xC0 followed by a data cycle starts an OTP write that is busy for PROG_CYCLES cycles.
- R11: Code 0x80 then 0xD0 enters buffered fast-program mode. A data cycle to the same partition starts a word program only while status bit 0 (word busy) is 0, and is discarded otherwise. A cycle to another partition leaves the mode.
- R12: 0xFF selects array reads, 0x70 status reads as {8'h00, status}, 0x90 ID_CODE and 0x98 QUERY_CODE. An array read from the partition of a running operation returns 0xFFFF.
- R13: A code outside the command set changes no read selection and starts no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write cycle strobe |
| wrPart | input | PART_W | Partition index of the write cycle |
| wrData | input | 16 | Write data; command code in bits 7:0 |
| rdPart | input | PART_W | Partition index of the current read |
| arrayData | input | 16 | Word supplied by the array model |
| rdData | output | 16 | Read output multiplexer |
| statusReg | output | 8 | Status byte |
| busy | output | 1 | Embedded operation counting |
| opStart | output | 1 | One-cycle pulse when an operation starts |
| opData | output | 16 | Data word of the cycle that started the last operation |

## Verification
A write sampled at clock edge k changes state, read selection and status combinationally after that edge. The bench therefore samples at the falling edge right after each write. opStart and opData are registered from the same edge, so they also appear at that falling edge. Busy time is counted in edges: an operation loaded at edge k is still busy after edge k+N-1 and idle after edge k+N. For each duration the bench checks busy once at N-1 cycles and once at N cycles, and for suspend it counts the decrements made before the suspend edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID, RD_QUERY} rdMode_t;

  typedef enum logic [3:0] {
    ST_READY, ST_PSETUP, ST_ESETUP, ST_LSETUP, ST_OSETUP, ST_BSETUP,
    ST_PBUSY, ST_EBUSY, ST_OBUSY, ST_BEFP, ST_PSUSP, ST_ESUSP,
    ST_PSETUP_ES, ST_PBUSY_ES, ST_ESETUP_PS
  } cmdState_t;

  typedef struct packed {
    logic startOp;   // load the busy counter
    logic longOp;    // erase duration instead of program duration
    logic hold;      // counter frozen (suspended)
    logic restore;   // reload saved erase count
    logic clrErr;
    logic seqErr;
    logic eSusp;
    logic pSusp;
    logic befp;
  } ctlStrobe_t;

  localparam logic [7:0] C_PROG   = 8'h40;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_ARRAY  = 8'hFF;
  localparam logic [7:0] C_STAT   = 8'h70;
  localparam logic [7:0] C_ID     = 8'h90;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_CLR    = 8'h50;
  localparam logic [7:0] C_LOCKS  = 8'h60;
  localparam logic [7:0] C_LOCK   = 8'h01;
  localparam logic [7:0] C_LDOWN  = 8'h2F;
  localparam logic [7:0] C_CFG    = 8'h03;
  localparam logic [7:0] C_OTP    = 8'hC0;
  localparam logic [7:0] C_FAST   = 8'h80;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int PART_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PART_W-1:0] wrPart,
  input  logic [7:0]        wrCode,
  input  logic              cntRun,
  input  logic              cntDone,
  output ctlStrobe_t        strb,
  output rdMode_t           rdMode,
  output logic [PART_W-1:0] busyPart
);

  cmdState_t state, nxtState;
  rdMode_t nxtMode;
  logic [PART_W-1:0] setupPart, nxtSetupPart, nxtBusyPart;
  logic samePart, cmdable, knownCode;

  assign samePart = (wrPart == setupPart);
  assign cmdable  = state inside {ST_READY, ST_PBUSY, ST_EBUSY, ST_OBUSY,
                                  ST_PSUSP, ST_ESUSP, ST_PBUSY_ES};
  assign knownCode = wrCode inside {C_PROG, C_ERASE, C_CONF, C_SUSP, C_ARRAY,
                                    C_STAT, C_ID, C_QUERY, C_CLR, C_LOCKS, C_OTP, C_FAST};

  always_comb begin
    nxtState     = state;
    nxtMode      = rdMode;
    nxtSetupPart = setupPart;
    nxtBusyPart  = busyPart;
    strb         = '0;
    strb.hold    = state inside {ST_PSUSP, ST_ESETUP_PS, ST_ESUSP, ST_PSETUP_ES};
    strb.eSusp   = state inside {ST_ESUSP, ST_PSETUP_ES, ST_PBUSY_ES};
    strb.pSusp   = state inside {ST_PSUSP, ST_ESETUP_PS};
    strb.befp    = (state == ST_BEFP);

    if (cntDone) begin
      case (state)
        ST_PBUSY, ST_EBUSY, ST_OBUSY: nxtState = ST_READY;
        ST_PBUSY_ES: begin nxtState = ST_ESUSP; strb.restore = 1'b1; end
        default: ;
      endcase
    end

    if (wrEn) begin
      if (cmdable) begin
        case (wrCode)
          C_ARRAY: nxtMode = RD_ARRAY;
          C_STAT:  nxtMode = RD_STATUS;
          C_ID:    nxtMode = RD_ID;
          C_QUERY: nxtMode = RD_QUERY;
          default: ;
        endcase
      end
      case (state)
        ST_READY: begin
          if (wrCode inside {C_PROG, C_ERASE, C_LOCKS, C_OTP, C_FAST}) begin
            nxtSetupPart = wrPart;
            nxtMode      = RD_STATUS;
          end
          case (wrCode)
            C_PROG:  nxtState = ST_PSETUP;
            C_ERASE: nxtState = ST_ESETUP;
            C_LOCKS: nxtState = ST_LSETUP;
            C_OTP:   nxtState = ST_OSETUP;
            C_FAST:  nxtState = ST_BSETUP;
            C_CLR:   strb.clrErr = 1'b1;
            default: ;
          endcase
        end
        ST_PSETUP, ST_OSETUP, ST_ESETUP, ST_LSETUP, ST_BSETUP: begin
          nxtMode  = RD_STATUS;
          nxtState = ST_READY;
          if (!samePart) strb.seqErr = 1'b1;
          else case (state)
            ST_PSETUP: begin strb.startOp = 1'b1; nxtState = ST_PBUSY; end
            ST_OSETUP: begin strb.startOp = 1'b1; nxtState = ST_OBUSY; end
            ST_ESETUP:
              if (wrCode == C_CONF) begin
                strb.startOp = 1'b1; strb.longOp = 1'b1; nxtState = ST_EBUSY;
              end else strb.seqErr = 1'b1;
            ST_LSETUP:
              if (!(wrCode inside {C_LOCK, C_LDOWN, C_CFG})) strb.seqErr = 1'b1;
            default:
              if (wrCode == C_CONF) nxtState = ST_BEFP;
              else strb.seqErr = 1'b1;
          endcase
          if (strb.startOp) nxtBusyPart = wrPart;
        end
        ST_PBUSY, ST_EBUSY:
          if (wrCode == C_SUSP && !cntDone) begin
            nxtState = (state == ST_PBUSY) ? ST_PSUSP : ST_ESUSP;
            nxtMode  = RD_STATUS;
          end
        ST_BEFP:
          if (!samePart) begin
            if (!cntRun) nxtState = ST_READY;
          end else if (!cntRun) begin
            strb.startOp = 1'b1;
            nxtBusyPart  = wrPart;
          end
        ST_PSUSP:
          case (wrCode)
            C_CONF:  begin nxtState = ST_PBUSY; nxtMode = RD_STATUS; end
            C_ERASE: nxtState = ST_ESETUP_PS;
            C_CLR:   strb.clrErr = 1'b1;
            default: ;
          endcase
        ST_ESETUP_PS: nxtState = ST_PSUSP;  // ambiguous second cycle dropped
        ST_ESUSP:
          case (wrCode)
            C_CONF: begin nxtState = ST_EBUSY; nxtMode = RD_STATUS; end
            C_PROG: begin nxtState = ST_PSETUP_ES; nxtSetupPart = wrPart; end
            C_CLR:  strb.clrErr = 1'b1;
            default: ;
          endcase
        ST_PSETUP_ES: begin
          nxtMode = RD_STATUS;
          if (samePart) begin
            strb.startOp = 1'b1;
            nxtBusyPart  = wrPart;
            nxtState     = ST_PBUSY_ES;
          end else begin
            strb.seqErr = 1'b1;
            nxtState    = ST_ESUSP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_READY;
      rdMode    <= RD_ARRAY;
      setupPart <= '0;
      busyPart  <= '0;
    end else begin
      state     <= nxtState;
      rdMode    <= nxtMode;
      setupPart <= nxtSetupPart;
      busyPart  <= nxtBusyPart;
    end
  end

  assert_ambiguous_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ESETUP_PS && wrEn) |=> (state == ST_PSUSP));

  assert_fast_discard_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BEFP && wrEn && cntRun) |-> !strb.startOp);

  assert_illegal_no_mode_R13: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && wrEn && !knownCode) |=> $stable(rdMode));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int          PART_W       = 2,
  parameter int          PROG_CYCLES  = 6,
  parameter int          ERASE_CYCLES = 12,
  parameter logic [15:0] ID_CODE      = 16'h00A7,
  parameter logic [15:0] QUERY_CODE   = 16'h0051
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [15:0]       wrData,
  input  rdMode_t           rdMode,
  input  logic [PART_W-1:0] busyPart,
  input  logic [PART_W-1:0] rdPart,
  input  logic [15:0]       arrayData,
  output logic              cntRun,
  output logic              cntDone,
  output logic [7:0]        statusReg,
  output logic [15:0]       rdData,
  output logic              opStart,
  output logic [15:0]       opData
);

  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt, savedCnt;
  logic [1:0] errBits;

  assign cntRun  = (cnt != '0) && !strb.hold;
  assign cntDone = cntRun && (cnt == CNT_W'(1));

  assign statusReg = {!cntRun, strb.eSusp, errBits, 1'b0, strb.pSusp, 1'b0,
                      strb.befp && cntRun};

  always_comb begin
    case (rdMode)
      RD_ARRAY:  rdData = (cntRun && rdPart == busyPart) ? 16'hFFFF : arrayData;
      RD_STATUS: rdData = {8'h00, statusReg};
      RD_ID:     rdData = ID_CODE;
      default:   rdData = QUERY_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      savedCnt <= '0;
      errBits  <= '0;
      opStart  <= 1'b0;
      opData   <= '0;
    end else begin
      if (strb.startOp) begin
        if (strb.eSusp) savedCnt <= cnt;
        cnt <= strb.longOp ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
      end else if (strb.restore) begin
        cnt <= savedCnt;
      end else if (cntRun) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (strb.seqErr)      errBits <= 2'b11;
      else if (strb.clrErr) errBits <= 2'b00;
      opStart <= strb.startOp;
      if (strb.startOp) opData <= wrData;
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.startOp |=> !statusReg[7]);

  assert_clear_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrErr |-> !cntRun);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errBits != 2'b00 && !strb.clrErr) |=> (errBits != 2'b00));

  assert_suspend_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && !strb.startOp) |=> $stable(cnt));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          PART_W       = 2,
  parameter int          PROG_CYCLES  = 6,
  parameter int          ERASE_CYCLES = 12,
  parameter logic [15:0] ID_CODE      = 16'h00A7,
  parameter logic [15:0] QUERY_CODE   = 16'h0051
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PART_W-1:0] wrPart,
  input  logic [15:0]       wrData,
  input  logic [PART_W-1:0] rdPart,
  input  logic [15:0]       arrayData,
  output logic [15:0]       rdData,
  output logic [7:0]        statusReg,
  output logic              busy,
  output logic              opStart,
  output logic [15:0]       opData
);

  ctlStrobe_t strb;
  rdMode_t rdMode;
  logic [PART_W-1:0] busyPart;
  logic cntRun, cntDone;

  assign busy = cntRun;

  flash_cmd_fsm #(.PART_W(PART_W)) uFsm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPart(wrPart), .wrCode(wrData[7:0]),
    .cntRun(cntRun), .cntDone(cntDone), .strb(strb), .rdMode(rdMode),
    .busyPart(busyPart)
  );

  flash_cmd_dp #(
    .PART_W(PART_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
    .ID_CODE(ID_CODE), .QUERY_CODE(QUERY_CODE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdMode(rdMode),
    .busyPart(busyPart), .rdPart(rdPart), .arrayData(arrayData),
    .cntRun(cntRun), .cntDone(cntDone), .statusReg(statusReg), .rdData(rdData),
    .opStart(opStart), .opData(opData)
  );

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int PART_W = 2;
  localparam int PROG   = 6;
  localparam int ERASE  = 12;
  localparam logic [15:0] IDW = 16'h00A7;
  localparam logic [15:0] QRW = 16'h0051;
  localparam logic [15:0] ARR = 16'h1234;

  // {data, expected rdData}; all cycles to partition 0
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    32'h0090_00A7, 32'h0070_0080, 32'h0098_0051, 32'h00FF_1234, 32'h0012_1234,
    32'h0070_0080, 32'h00A5_0080, 32'h0090_00A7, 32'h0050_00A7
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [PART_W-1:0] wrPart = '0;
  logic [15:0] wrData = '0;
  logic [PART_W-1:0] rdPart = '0;
  logic [15:0] arrayData = ARR;
  logic [15:0] rdData, opData;
  logic [7:0] statusReg;
  logic busy, opStart;
  int total = 0;
  int bad = 0;
  int opCnt = 0;
  int snap;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.PART_W(PART_W), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
                   .ID_CODE(IDW), .QUERY_CODE(QRW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPart(wrPart), .wrData(wrData),
    .rdPart(rdPart), .arrayData(arrayData), .rdData(rdData), .statusReg(statusReg),
    .busy(busy), .opStart(opStart), .opData(opData)
  );

  always @(negedge clk) if (opStart) opCnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [PART_W-1:0] p, input logic [15:0] d);
    wrEn = 1'b1; wrPart = p; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 rdData", rdData, ARR);
    chk("R1 status", {8'h0, statusReg}, 16'h0080);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 opStart", {15'h0, opStart}, 16'h0);

    // R12 / R13 table walk
    for (int i = 0; i < NV; i++) begin
      wr('0, VEC[i][31:16]);
      chk((VEC[i][23:16] == 8'h12 || VEC[i][23:16] == 8'hA5) ? "R13 illegal" : "R12 mux",
          rdData, VEC[i][15:0]);
    end
    chk("R13 no op", opCnt[15:0], 16'h0);

    // R2 word program
    wr(0, 16'h0040); wr(0, 16'hBEEF);
    chk("R2 opStart", {15'h0, opStart}, 16'h1);
    chk("R2 opData", opData, 16'hBEEF);
    chk("R2 status read", rdData, 16'h0000);
    idle(PROG - 1);
    chk("R2 still busy", {15'h0, busy}, 16'h1);
    idle(1);
    chk("R2 done", {8'h0, statusReg}, 16'h0080);

    // R12 busy partition array read
    wr(1, 16'h0040); wr(1, 16'h1111); wr(0, 16'h00FF);
    rdPart = 1; #1;
    chk("R12 busy part", rdData, 16'hFFFF);
    rdPart = 0; #1;
    chk("R12 other part", rdData, ARR);
    idle(PROG);
    rdPart = 1; #1;
    chk("R12 after done", rdData, ARR);
    rdPart = 0;

    // R4 partition mismatch and wrong confirm; R5 sticky/clear
    snap = opCnt;
    wr(0, 16'h0040); wr(1, 16'h5555);
    chk("R4 mismatch", {8'h0, statusReg}, 16'h00B0);
    chk("R4 no start", {15'h0, opStart}, 16'h0);
    wr(0, 16'h0040); wr(0, 16'h7777); wr(0, 16'h0050);
    idle(PROG);
    chk("R5 clear ignored busy", {8'h0, statusReg}, 16'h00B0);
    wr(0, 16'h0050);
    chk("R5 clear idle", {8'h0, statusReg}, 16'h0080);
    wr(0, 16'h0020); wr(0, 16'h0033);
    chk("R4 bad confirm", {8'h0, statusReg}, 16'h00B0);
    wr(0, 16'h0050);
    wr(0, 16'h0020); wr(1, 16'h00D0);
    chk("R4 erase mismatch", {8'h0, statusReg}, 16'h00B0);
    chk("R4 op count", 16'(opCnt - snap), 16'h1);
    wr(0, 16'h0050);

    // R3 erase
    wr(0, 16'h0020); wr(0, 16'h00D0);
    idle(ERASE - 1);
    chk("R3 busy", {15'h0, busy}, 16'h1);
    idle(1);
    chk("R3 done", {8'h0, statusReg}, 16'h0080);

    // R6 program suspend / resume
    wr(0, 16'h0040); wr(0, 16'hAAAA);
    idle(2);
    wr(0, 16'h00B0);
    chk("R6 suspended", {8'h0, statusReg}, 16'h0084);
    idle(5);
    chk("R6 frozen", {8'h0, statusReg}, 16'h0084);
    wr(0, 16'h00D0);
    idle(2);
    chk("R6 resumed busy", {15'h0, busy}, 16'h1);
    idle(1);
    chk("R6 resumed done", {8'h0, statusReg}, 16'h0080);

    // R7 ambiguous erase during program suspend
    wr(0, 16'h0040); wr(0, 16'hCCCC); wr(0, 16'h00B0);
    #1 snap = opCnt;
    wr(0, 16'h0020); wr(0, 16'h00D0);
    chk("R7 still suspended", {8'h0, statusReg}, 16'h0084);
    #1 chk("R7 no op", 16'(opCnt - snap), 16'h0);
    wr(0, 16'h00D0);
    idle(5);
    chk("R7 resume done", {8'h0, statusReg}, 16'h0080);

    // R8 program within erase suspend
    wr(0, 16'h0020); wr(0, 16'h00D0); wr(0, 16'h00B0);
    chk("R8 erase suspended", {8'h0, statusReg}, 16'h00C0);
    wr(1, 16'h0040); wr(1, 16'h9999);
    chk("R8 nested start", opData, 16'h9999);
    chk("R8 nested busy", {8'h0, statusReg}, 16'h0040);
    idle(PROG);
    chk("R8 back to suspend", {8'h0, statusReg}, 16'h00C0);
    wr(0, 16'h00D0);
    idle(10);
    chk("R8 erase resumed", {15'h0, busy}, 16'h1);
    idle(1);
    chk("R8 erase done", {8'h0, statusReg}, 16'h0080);

    // R9 lock / configuration confirms
    wr(0, 16'h0060); wr(0, 16'h0001);
    chk("R9 lock", rdData, 16'h0080);
    wr(0, 16'h0060); wr(0, 16'h002F);
    chk("R9 lock-down", {8'h0, statusReg}, 16'h0080);
    wr(0, 16'h0060); wr(0, 16'h0003);
    chk("R9 config", {8'h0, statusReg}, 16'h0080);
    wr(0, 16'h0060); wr(0, 16'h0077);
    chk("R9 bad confirm", {8'h0, statusReg}, 16'h00B0);
    wr(0, 16'h0050);

    // R10 OTP
    wr(0, 16'h00C0); wr(0, 16'h0F0F);
    chk("R10 busy", {15'h0, busy}, 16'h1);
    chk("R10 data", opData, 16'h0F0F);
    idle(PROG);
    chk("R10 done", {8'h0, statusReg}, 16'h0080);

    // R11 buffered fast program
    wr(0, 16'h0080); wr(0, 16'h00D0);
    chk("R11 entered", {8'h0, statusReg}, 16'h0080);
    wr(0, 16'h1111);
    chk("R11 accept", opData, 16'h1111);
    chk("R11 word busy", {8'h0, statusReg}, 16'h0001);
    wr(0, 16'h2222);
    chk("R11 discard", opData, 16'h1111);
    chk("R11 discard pulse", {15'h0, opStart}, 16'h0);
    idle(PROG);
    chk("R11 word done", {8'h0, statusReg}, 16'h0080);
    wr(0, 16'h3333);
    chk("R11 accept again", opData, 16'h3333);
    idle(PROG);
    wr(1, 16'h0000);
    wr(0, 16'h0090);
    chk("R11 exit", rdData, IDW);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule